// File: doc/BRIEF.md
# Cartridge Bank Address Translator

This block maps the CPU's 32K program window and the video side's 8K picture window onto physical ROM pages. It also reports the nametable mirroring arrangement. Its inputs are four 5-bit bank registers, which are loaded elsewhere: a control register, two picture bank registers and a program bank register. The program window is divided into four 8K slots and the picture window into eight 1K slots. The block works out which physical page each slot points at and appends the untouched low address bits.

The translation is purely combinational. The ROM sizes are parameters, and every page number is wrapped to the ROM size by keeping only its low bits. This means the page counts must be powers of two. Program ROMs larger than 256K are handled as 256K regions. When the picture side has no ROM of its own, the top bit of the first picture register selects the region.

Top module: `cart_bank_xlate`

## Requirements
- R1: `mirror_code` is 0 when `ctrl_reg[1:0]` is 11, 1 when it is 10, 2 when it is 01 and 3 when it is 00. Codes 2 and 3 are the single-screen arrangements.
- R2: When `ctrl_reg[3]` is 0, program slot s (s = `cpu_addr[14:13]`) maps to 8K page 2*`prg_reg` + s. This makes the register a 16K-unit index and the window one 32K bank.
- R3: When `ctrl_reg[3:2]` is 11, slots 0 and 1 map to pages 2*`prg_reg` and 2*`prg_reg`+1. Slots 2 and 3 are fixed to the last two 8K pages of the active 256K region, or of the whole ROM if it is 256K or smaller.
- R4: When `ctrl_reg[3:2]` is 10, slots 0 and 1 are fixed to the first two pages of the active region. Slots 2 and 3 map to pages 2*`prg_reg` and 2*`prg_reg`+1.
- R5: When `ctrl_reg[4]` is 1, picture addresses with `ppu_addr[12]`=0 map to 1K page 4*`chr0_reg` + `ppu_addr[11:10]`. Those with `ppu_addr[12]`=1 map to 4*`chr1_reg` + `ppu_addr[11:10]`.
- R6: When `ctrl_reg[4]` is 0, picture slot t (`ppu_addr[12:10]`) maps to 1K page 4*`chr0_reg` + t. This is an 8K window starting at that 4K bank, and `chr1_reg` is ignored.
- R7: If the program ROM is larger than 256K and the picture side is RAM, `chr0_reg[4]` adds 32 pages to every program page, so it selects the 256K half.
- R8: For program ROMs larger than 256K, the fixed last 16K is pages 30 and 31 of the active region, not the last pages of the whole ROM.
- R9: `prg_phys` is {program page, `cpu_addr[12:0]`} and `chr_phys` is {picture page, `ppu_addr[9:0]`}.
- R10: Every program bank number is first reduced modulo 32 within its region. Every resulting page is then reduced modulo the page count of its ROM, so out-of-range selections wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctrl_reg | input | 5 | Control: mirroring [1:0], fixed-slot select [2], 16K mode [3], 4K picture mode [4] |
| chr0_reg | input | 5 | First picture bank register |
| chr1_reg | input | 5 | Second picture bank register |
| prg_reg | input | 5 | Program bank register |
| cpu_addr | input | 15 | CPU offset inside the 32K program window |
| ppu_addr | input | 13 | Offset inside the 8K picture window |
| prg_phys | output | log2(PRG_PAGES)+13 | Physical program ROM byte address |
| chr_phys | output | log2(CHR_PAGES)+10 | Physical picture memory byte address |
| mirror_code | output | 2 | Nametable mirroring code |

## Verification
The block holds no state, so a fault in its slot decode appears on the very address presented, in the same cycle. Such a fault shows up as the wrong page in the upper bits of `prg_phys` or `chr_phys`. A mistake in the fixed-slot logic is visible only when the CPU offset falls in the fixed half, and a mistake in the region or wrap logic only when bank numbers exceed the ROM size. For that reason, stimulus sweeps all four program slots in each mode, out-of-range bank values, and a second instance with a 512K program ROM and picture RAM.

// File: rtl/cart_bank_xlate.sv
module cart_bank_xlate #(
  parameter int PRG_PAGES = 16,
  parameter int CHR_PAGES = 16,
  parameter bit CHR_RAM   = 1'b0
) (
  input  logic [4:0]  ctrl_reg,
  input  logic [4:0]  chr0_reg,
  input  logic [4:0]  chr1_reg,
  input  logic [4:0]  prg_reg,
  input  logic [14:0] cpu_addr,
  input  logic [12:0] ppu_addr,
  output logic [$clog2(PRG_PAGES)+12:0] prg_phys,
  output logic [$clog2(CHR_PAGES)+9:0]  chr_phys,
  output logic [1:0]  mirror_code
);
  localparam int PRG_PW   = $clog2(PRG_PAGES);
  localparam int CHR_PW   = $clog2(CHR_PAGES);
  localparam int REGION   = 32;
  localparam bit WIDE_PRG = PRG_PAGES > REGION;
  localparam bit OUTER_EN = WIDE_PRG && CHR_RAM;
  localparam logic [4:0] FIX_LO = WIDE_PRG ? 5'(REGION - 2) : 5'(PRG_PAGES - 2);

  logic [1:0]        slot;
  logic [5:0]        sel16;
  logic [4:0]        rel;
  logic              outer;
  logic [PRG_PW-1:0] prg_page;
  logic [4:0]        chr_sel;
  logic [2:0]        chr_off;
  logic [CHR_PW-1:0] chr_page;

  assign slot  = cpu_addr[14:13];
  assign sel16 = {prg_reg, 1'b0};
  assign outer = OUTER_EN ? chr0_reg[4] : 1'b0;

  always_comb begin
    if (!ctrl_reg[3])
      rel = 5'(sel16 + 6'(slot));
    else if (ctrl_reg[2])
      rel = slot[1] ? FIX_LO + 5'(slot[0]) : 5'(sel16 + 6'(slot[0]));
    else
      rel = slot[1] ? 5'(sel16 + 6'(slot[0])) : 5'(slot[0]);
  end

  assign prg_page = PRG_PW'({outer, rel});
  assign prg_phys = {prg_page, cpu_addr[12:0]};

  always_comb begin
    if (ctrl_reg[4]) begin
      chr_sel = ppu_addr[12] ? chr1_reg : chr0_reg;
      chr_off = {1'b0, ppu_addr[11:10]};
    end else begin
      chr_sel = chr0_reg;
      chr_off = ppu_addr[12:10];
    end
  end

  assign chr_page    = CHR_PW'(8'({chr_sel, 2'b00}) + 8'(chr_off));
  assign chr_phys    = {chr_page, ppu_addr[9:0]};
  assign mirror_code = ~ctrl_reg[1:0];

  always_comb begin
    // R3
    if (ctrl_reg[3] && ctrl_reg[2] && cpu_addr[14:13] == 2'b11)
      fixed_top_chk: assert (prg_phys[PRG_AW_TOP:13] ==
        PRG_PW'((OUTER_EN && chr0_reg[4]) ? 63 : (WIDE_PRG ? 31 : PRG_PAGES - 1)))
        else $error("fixed top page wrong");
  end

  always_comb begin
    // R4
    if (ctrl_reg[3] && !ctrl_reg[2] && !cpu_addr[14])
      fixed_low_chk: assert (prg_phys[PRG_AW_TOP:13] ==
        PRG_PW'(((OUTER_EN && chr0_reg[4]) ? 32 : 0) + int'(cpu_addr[13])))
        else $error("fixed low page wrong");
  end

  always_comb begin
    // R2
    if (!ctrl_reg[3])
      pair_parity_chk: assert (prg_phys[13] == cpu_addr[13])
        else $error("32K pairing broken");
  end

  always_comb begin
    // R5
    if (ctrl_reg[4])
      half_slot_chk: assert (chr_phys[11:10] == ppu_addr[11:10])
        else $error("4K picture offset wrong");
  end

  localparam int PRG_AW_TOP = PRG_PW + 12;
endmodule

// File: tb/cart_bank_xlate_tb_top.sv
module cart_bank_xlate_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [4:0]  ctrl_reg, chr0_reg, chr1_reg, prg_reg;
  logic [14:0] cpu_addr;
  logic [12:0] ppu_addr;
  logic [16:0] prg_phys;
  logic [13:0] chr_phys;
  logic [1:0]  mirror_code;
  logic [18:0] big_prg;
  logic [12:0] big_chr;
  logic [1:0]  big_mir;

  cart_bank_xlate dut_i (
    .ctrl_reg(ctrl_reg), .chr0_reg(chr0_reg), .chr1_reg(chr1_reg), .prg_reg(prg_reg),
    .cpu_addr(cpu_addr), .ppu_addr(ppu_addr),
    .prg_phys(prg_phys), .chr_phys(chr_phys), .mirror_code(mirror_code));

  cart_bank_xlate #(.PRG_PAGES(64), .CHR_PAGES(8), .CHR_RAM(1'b1)) dut_big_i (
    .ctrl_reg(ctrl_reg), .chr0_reg(chr0_reg), .chr1_reg(chr1_reg), .prg_reg(prg_reg),
    .cpu_addr(cpu_addr), .ppu_addr(ppu_addr),
    .prg_phys(big_prg), .chr_phys(big_chr), .mirror_code(big_mir));

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  // ctrl, chr0, chr1, prg, cpu, ppu, exp prg page, exp chr page, exp mirror
  localparam int NV = 14;
  localparam logic [57:0] VEC [NV] = '{
    {5'b00011, 5'd2,  5'd0,  5'd3,  15'h0123, 13'h0010, 4'd6,  4'd8,  2'd0},
    {5'b00010, 5'd2,  5'd0,  5'd3,  15'h6005, 13'h1C00, 4'd9,  4'd15, 2'd1},
    {5'b01101, 5'd1,  5'd0,  5'd5,  15'h2000, 13'h0800, 4'd11, 4'd6,  2'd2},
    {5'b01100, 5'd1,  5'd0,  5'd5,  15'h4000, 13'h0400, 4'd14, 4'd5,  2'd3},
    {5'b01100, 5'd0,  5'd0,  5'd5,  15'h7FFF, 13'h0000, 4'd15, 4'd0,  2'd3},
    {5'b01000, 5'd0,  5'd0,  5'd5,  15'h0000, 13'h0000, 4'd0,  4'd0,  2'd3},
    {5'b01000, 5'd0,  5'd0,  5'd5,  15'h2ABC, 13'h0000, 4'd1,  4'd0,  2'd3},
    {5'b01000, 5'd0,  5'd0,  5'd5,  15'h4000, 13'h0000, 4'd10, 4'd0,  2'd3},
    {5'b01000, 5'd0,  5'd0,  5'd5,  15'h6000, 13'h0000, 4'd11, 4'd0,  2'd3},
    {5'b10011, 5'd3,  5'd2,  5'd0,  15'h0000, 13'h0C00, 4'd0,  4'd15, 2'd0},
    {5'b10011, 5'd3,  5'd2,  5'd0,  15'h0000, 13'h1400, 4'd0,  4'd9,  2'd0},
    {5'b00011, 5'd5,  5'd0,  5'd9,  15'h2000, 13'h1800, 4'd3,  4'd10, 2'd0},
    {5'b10011, 5'd0,  5'd31, 5'd0,  15'h0000, 13'h1C00, 4'd0,  4'd15, 2'd0},
    {5'b01111, 5'd0,  5'd0,  5'd20, 15'h2000, 13'h0000, 4'd9,  4'd0,  2'd0}
  };
  localparam string VTAG [NV] = '{"R2", "R1", "R3", "R3", "R3", "R4", "R4", "R4", "R4",
                                  "R5", "R5", "R10", "R10", "R10"};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [4:0] c, input logic [4:0] r0, input logic [4:0] r1,
                       input logic [4:0] p, input logic [14:0] ca, input logic [12:0] pa);
    @(posedge clk);
    ctrl_reg = c; chr0_reg = r0; chr1_reg = r1; prg_reg = p; cpu_addr = ca; ppu_addr = pa;
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    ctrl_reg = '0; chr0_reg = '0; chr1_reg = '0; prg_reg = '0; cpu_addr = '0; ppu_addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // idle outputs during reset with all-zero registers: R2, R6, R1
    chk("R2 idle prg", 32'(prg_phys), 32'h0);
    chk("R6 idle chr", 32'(chr_phys), 32'h0);
    chk("R1 idle mirror", 32'(mirror_code), 32'd3);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][57:53], VEC[i][52:48], VEC[i][47:43], VEC[i][42:38],
            VEC[i][37:23], VEC[i][22:10]);
      chk(VTAG[i], 32'(prg_phys[16:13]), 32'(VEC[i][9:6]));
      chk(VTAG[i], 32'(chr_phys[13:10]), 32'(VEC[i][5:2]));
      chk("R1", 32'(mirror_code), 32'(VEC[i][1:0]));
    end

    // R9 full address formation
    drive(5'b00011, 5'd1, 5'd0, 5'd2, 15'h3456, 13'h0ABC);
    chk("R9 prg addr", 32'(prg_phys), {15'd0, 4'd5, 13'h1456});
    chk("R9 chr addr", 32'(chr_phys), {18'd0, 4'd6, 10'h2BC});

    // R6 second picture register ignored in 8K mode
    drive(5'b00011, 5'd1, 5'd17, 5'd2, 15'h0000, 13'h1000);
    chk("R6 chr1 ignored", 32'(chr_phys[13:10]), 32'd8);

    // R7 region select on the 512K / picture-RAM instance
    drive(5'b01100, 5'b10000, 5'd0, 5'd2, 15'h0000, 13'h0000);
    chk("R7 big slot0", 32'(big_prg[18:13]), 32'd36);
    chk("R10 big chr wrap", 32'(big_chr[12:10]), 32'd0);
    drive(5'b01100, 5'b10000, 5'd0, 5'd2, 15'h6000, 13'h0000);
    chk("R8 big fixed top upper", 32'(big_prg[18:13]), 32'd63);
    drive(5'b01100, 5'd0, 5'd0, 5'd2, 15'h4000, 13'h0000);
    chk("R8 big fixed region0", 32'(big_prg[18:13]), 32'd30);
    drive(5'b00000, 5'b10000, 5'd0, 5'd15, 15'h6000, 13'h0000);
    chk("R10 big region wrap", 32'(big_prg[18:13]), 32'd33);
    drive(5'b01000, 5'b10000, 5'd0, 5'd7, 15'h2000, 13'h0000);
    chk("R4 big fixed low", 32'(big_prg[18:13]), 32'd33);
    drive(5'b10000, 5'b10000, 5'd1, 5'd0, 15'h0000, 13'h1400);
    chk("R5 big chr hi", 32'(big_chr), {3'd5, 10'h000});
    drive(5'b10000, 5'b10000, 5'd1, 5'd0, 15'h0000, 13'h0400);
    chk("R5 big chr lo", 32'(big_chr), {3'd1, 10'h000});
    // R7 picture-ROM instance ignores the region bit
    drive(5'b01100, 5'b10000, 5'd0, 5'd2, 15'h0000, 13'h0000);
    chk("R7 small no region", 32'(prg_phys[16:13]), 32'd4);

    finish_run();
  end

  initial begin
    repeat (10000) @(posedge clk);
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end
endmodule